// File: doc/BRIEF.md
# Programmable-Logic Configuration Sequencer

This block moves an attached programmable-logic target through its bring-up phases: powered off, held in reset, accepting configuration, initialising, and running the user design. Software drives it through a small 32-bit register window. The control word enables the sequencer, sets the target's active-low chip-enable, and requests a configuration pull that puts the target into reset. The status word reports the current phase as a 3-bit code, which software polls between steps.

After the pull is released and the target reports a healthy status, the phase becomes configuration. In that phase a gate bit opens a data port, and each word written to the port is forwarded to the target as a one-cycle valid pulse. Once the target raises config-done and software closes the gate, the sequencer issues a fixed number of configuration clock pulses and then enters the user phase. A write to the data port while the gate is closed is dropped and sets a sticky error flag. The mode-select pins are captured once after reset and read back in the status word.

Top module: `cfgseq_mgr`

## Requirements
- R1: After reset the phase reads 0, the control word reads 0x002, the error flag reads 0, tgt_nce and tgt_nconfig are high, and tgt_data_vld is low.
- R2: Status bits [7:3] return mode_pins as captured on the first clock after reset. Later changes on the pins do not alter the readback.
- R3: The control word at byte offset 0x4 holds enable (bit 0), chip-enable (bit 1, active low), pull (bit 2), ratio code (bits [7:6]), data gate (bit 8) and wide data (bit 9, 1 = 32 bits). Every other bit, and every unlisted bit of the status and pin words, reads 0.
- R4: With enable and pull both set, the phase reads 1 (reset) one clock after the control write takes effect, from any phase. While enabled, tgt_nconfig is the inverse of pull and tgt_nce follows bit 1.
- R5: In phase 1 with pull clear, the phase moves to 2 (configuration) only after tgt_nstatus has been high through the input synchroniser.
- R6: A write to the data port at offset 0xC while enable and gate are set produces tgt_data_vld high for exactly the next cycle. tgt_data holds the word, with bits [31:16] forced to 0 when bit 9 is 0.
- R7: A data-port write while enable or gate is clear gives no valid pulse and sets status bit 8. Writing 1 to status bit 8 clears it.
- R8: In phase 2, once the synchronised config-done is high and the gate is clear, the phase becomes 3. The sequencer emits DCLK_PULSES high pulses on tgt_dclk, one every two cycles, and then the phase becomes 4 (user). While the gate is open the phase stays at 2.
- R9: Bit 10 of the pin word at offset 0x8 shows tgt_conf_done after SYNC_STAGES clocks.
- R10: Clearing enable returns tgt_nce and tgt_nconfig high and cfg_ratio to 0. The phase stays 4 if it is 4 and otherwise returns to 0. With enable clear, pull has no effect on the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mode_pins | input | 5 | External mode-select pins |
| tgt_nstatus | input | 1 | Target status, high when healthy |
| tgt_conf_done | input | 1 | Target config-done |
| tgt_nce | output | 1 | Target chip-enable, active low |
| tgt_nconfig | output | 1 | Target configuration pull, active low |
| tgt_dclk | output | 1 | Configuration clock pulses during initialisation |
| cfg_ratio | output | 2 | Clock-to-data ratio code while enabled |
| tgt_data | output | 32 | Configuration word toward the target |
| tgt_data_vld | output | 1 | One-cycle valid for tgt_data |

## Verification
A control write takes effect at the clock edge that samples it. The chip-enable and pull outputs and the control readback follow that edge at once, and the phase code changes one edge later. The target inputs pass through SYNC_STAGES flops, so the pin word changes SYNC_STAGES edges after an input change and the phase one edge after that. A forwarded data word shows its valid pulse in the cycle after the write edge. The bench drives on falling edges and samples on the falling edge where each result is due. It also checks the falling edge just before, so a result that arrives early or late is reported.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [2:0] {
      PH_OFF  = 3'd0,
      PH_RST  = 3'd1,
      PH_CFG  = 3'd2,
      PH_INIT = 3'd3,
      PH_USER = 3'd4
   } phase_e;

   typedef struct packed {
      logic       wide;
      logic       gate;
      logic [1:0] ratio;
      logic       pull;
      logic       nce;
      logic       en;
   } ctrl_t;

   // word index of each register (byte address bits [3:2])
   localparam logic [1:0] IDX_STAT = 2'd0;
   localparam logic [1:0] IDX_CTRL = 2'd1;
   localparam logic [1:0] IDX_PINS = 2'd2;
   localparam logic [1:0] IDX_DATA = 2'd3;

   localparam int BUS_W    = 32;
   localparam int MSEL_W   = 5;
   localparam int SB_ERR   = 8;
   localparam int PB_CDONE = 10;
   localparam int HALF_W   = BUS_W / 2;

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("cfgseq_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] ff_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ff_q <= '0;
         end else begin
            ff_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               ff_q[i] <= ff_q[i-1];
            end
         end
      end
      assign q = ff_q[STAGES-1];
   end

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
   import cfgseq_pkg::*;
#(
   parameter int DCLK_PULSES = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   pull,
   input  logic   gate,
   input  logic   nstatus_s,
   input  logic   cdone_s,
   output phase_e phase,
   output logic   dclk
);

   localparam int INIT_CYC = 2 * DCLK_PULSES;
   localparam int CNT_W    = (INIT_CYC > 2) ? $clog2(INIT_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYC - 1);

   if (DCLK_PULSES < 1 || DCLK_PULSES > 1024) begin : g_bad_pulses
      $error("cfgseq_fsm: DCLK_PULSES must be 1..1024");
   end

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      phase_d = phase_q;
      if (!en) begin
         phase_d = (phase_q == PH_USER) ? PH_USER : PH_OFF;
      end else if (pull) begin
         phase_d = PH_RST;
      end else begin
         unique case (phase_q)
            PH_RST:  if (nstatus_s)         phase_d = PH_CFG;
            PH_CFG:  if (cdone_s && !gate)  phase_d = PH_INIT;
            PH_INIT: if (cnt_q == CNT_LAST) phase_d = PH_USER;
            default: phase_d = phase_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= (phase_q == PH_INIT) ? cnt_q + 1'b1 : '0;
      end
   end

   assign phase = phase_q;
   assign dclk  = (phase_q == PH_INIT) && !cnt_q[0];

   // pulses seen during the current initialisation phase, for the checks below
   logic [CNT_W:0] pulse_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pulse_seen_q <= '0;
      else if (phase_q == PH_INIT) pulse_seen_q <= pulse_seen_q + {{CNT_W{1'b0}}, dclk};
      else                         pulse_seen_q <= '0;
   end

   a_r4_pull_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pull) |=> (phase == PH_RST));

   a_r8_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_USER && $past(phase) == PH_INIT) |-> (pulse_seen_q == (CNT_W+1)'(DCLK_PULSES)));

   a_r10_user_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_USER && !en) |=> (phase == PH_USER));

   a_r5_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RST) |=> (phase == PH_RST || phase == PH_CFG || phase == PH_OFF));

endmodule

// File: rtl/cfgseq_regs.sv
module cfgseq_regs
   import cfgseq_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [MSEL_W-1:0] mode_pins,
   input  phase_e            phase,
   input  logic              cdone_s,
   output ctrl_t             ctrl,
   output logic [BUS_W-1:0]  fwd_data,
   output logic              fwd_vld
);

   if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
      $error("cfgseq_regs: ADDR_W must be 4..32");
   end

   logic       hit;
   logic [1:0] idx;
   logic [1:0] addr_lsb_unused;

   assign idx             = bus_addr[3:2];
   assign addr_lsb_unused = bus_addr[1:0];

   if (ADDR_W > 4) begin : g_upper_dec
      assign hit = (bus_addr[ADDR_W-1:4] == '0);
   end else begin : g_flat_dec
      assign hit = 1'b1;
   end

   logic wr_stat, wr_ctrl, wr_data, data_open;
   assign wr_stat   = bus_wr && hit && (idx == IDX_STAT);
   assign wr_ctrl   = bus_wr && hit && (idx == IDX_CTRL);
   assign wr_data   = bus_wr && hit && (idx == IDX_DATA);
   assign data_open = ctrl.en && ctrl.gate;

   ctrl_t             ctrl_q;
   logic              err_q;
   logic              latched_q;
   logic [MSEL_W-1:0] msel_q;
   logic [BUS_W-1:0]  fwd_data_q;
   logic              fwd_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '{wide: 1'b0, gate: 1'b0, ratio: 2'd0, pull: 1'b0, nce: 1'b1, en: 1'b0};
         err_q     <= 1'b0;
         latched_q <= 1'b0;
         msel_q    <= '0;
      end else begin
         if (!latched_q) begin
            msel_q    <= mode_pins;
            latched_q <= 1'b1;
         end
         if (wr_ctrl) begin
            ctrl_q.en    <= bus_wdata[0];
            ctrl_q.nce   <= bus_wdata[1];
            ctrl_q.pull  <= bus_wdata[2];
            ctrl_q.ratio <= bus_wdata[7:6];
            ctrl_q.gate  <= bus_wdata[8];
            ctrl_q.wide  <= bus_wdata[9];
         end
         if (wr_data && !data_open)          err_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_ERR]) err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_data_q <= '0;
         fwd_vld_q  <= 1'b0;
      end else begin
         fwd_vld_q <= wr_data && data_open;
         if (wr_data && data_open) begin
            fwd_data_q <= ctrl_q.wide ? bus_wdata
                                      : {{HALF_W{1'b0}}, bus_wdata[HALF_W-1:0]};
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (idx)
            IDX_STAT: begin
               bus_rdata[2:0]    = phase;
               bus_rdata[7:3]    = msel_q;
               bus_rdata[SB_ERR] = err_q;
            end
            IDX_CTRL: begin
               bus_rdata[0]   = ctrl_q.en;
               bus_rdata[1]   = ctrl_q.nce;
               bus_rdata[2]   = ctrl_q.pull;
               bus_rdata[7:6] = ctrl_q.ratio;
               bus_rdata[8]   = ctrl_q.gate;
               bus_rdata[9]   = ctrl_q.wide;
            end
            IDX_PINS: bus_rdata[PB_CDONE] = cdone_s;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign ctrl     = ctrl_q;
   assign fwd_data = fwd_data_q;
   assign fwd_vld  = fwd_vld_q;

   a_r2_msel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      latched_q |=> $stable(msel_q));

   a_r7_closed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !data_open) |=> (!fwd_vld && err_q));

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_vld && !$past(wr_data)) |-> 1'b0);

endmodule

// File: rtl/cfgseq_mgr.sv
module cfgseq_mgr
   import cfgseq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DCLK_PULSES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [4:0]        mode_pins,
   input  logic              tgt_nstatus,
   input  logic              tgt_conf_done,
   output logic              tgt_nce,
   output logic              tgt_nconfig,
   output logic              tgt_dclk,
   output logic [1:0]        cfg_ratio,
   output logic [31:0]       tgt_data,
   output logic              tgt_data_vld
);

   ctrl_t  ctrl;
   phase_e phase;
   logic   nstatus_s, cdone_s;

   cfgseq_sync #(.STAGES(SYNC_STAGES)) u_sync_nstatus (
      .clk(clk), .rst_n(rst_n), .d(tgt_nstatus), .q(nstatus_s));

   cfgseq_sync #(.STAGES(SYNC_STAGES)) u_sync_cdone (
      .clk(clk), .rst_n(rst_n), .d(tgt_conf_done), .q(cdone_s));

   cfgseq_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .mode_pins(mode_pins),
      .phase(phase), .cdone_s(cdone_s), .ctrl(ctrl),
      .fwd_data(tgt_data), .fwd_vld(tgt_data_vld));

   cfgseq_fsm #(.DCLK_PULSES(DCLK_PULSES)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl.en), .pull(ctrl.pull), .gate(ctrl.gate),
      .nstatus_s(nstatus_s), .cdone_s(cdone_s),
      .phase(phase), .dclk(tgt_dclk));

   assign tgt_nce     = ctrl.en ? ctrl.nce   : 1'b1;
   assign tgt_nconfig = ctrl.en ? !ctrl.pull : 1'b1;
   assign cfg_ratio   = ctrl.en ? ctrl.ratio : 2'd0;

   a_r4_pull_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!tgt_nconfig) |=> (phase == PH_RST));

   a_r10_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF && $past(phase) == PH_OFF && !$past(ctrl.en)) |-> (tgt_dclk == 1'b0));

endmodule

// File: tb/cfgseq_mgr_tb_top.sv
module cfgseq_mgr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  mode_pins = 5'h0B;
   logic        tgt_nstatus = 1'b0;
   logic        tgt_conf_done = 1'b0;
   logic        tgt_nce, tgt_nconfig, tgt_dclk, tgt_data_vld;
   logic [1:0]  cfg_ratio;
   logic [31:0] tgt_data;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cfgseq_mgr #(.ADDR_W(4), .SYNC_STAGES(2), .DCLK_PULSES(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_pins(mode_pins),
      .tgt_nstatus(tgt_nstatus), .tgt_conf_done(tgt_conf_done),
      .tgt_nce(tgt_nce), .tgt_nconfig(tgt_nconfig), .tgt_dclk(tgt_dclk),
      .cfg_ratio(cfg_ratio), .tgt_data(tgt_data), .tgt_data_vld(tgt_data_vld));

   localparam logic [31:0] MSEL_FIELD = 32'h0B << 3;

   // control writes with enable clear, and the expected readback
   localparam logic [31:0] VEC_W [0:5] = '{32'hFFFF_FFFE, 32'h0000_0040, 32'h0000_0080,
                                          32'h0000_0200, 32'hFFFF_FC38, 32'h0000_0006};
   localparam logic [31:0] VEC_E [0:5] = '{32'h0000_03C6, 32'h0000_0040, 32'h0000_0080,
                                          32'h0000_0200, 32'h0000_0000, 32'h0000_0006};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h want 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic chk_phase(input string req, input logic [2:0] exp);
      logic [31:0] s;
      rd(4'h0, s);
      chk(req, {29'd0, s[2:0]}, {29'd0, exp});
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got 0x%08h want 0x%08h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] r;
      int pulses;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, r);  chk("R1 status", r, MSEL_FIELD);
      rd(4'h4, r);  chk("R1 control", r, 32'h2);
      chk("R1 outputs", {28'd0, tgt_nce, tgt_nconfig, tgt_data_vld, tgt_dclk}, 32'hC);

      // R2 pins change after capture
      mode_pins = 5'h15;
      repeat (2) @(negedge clk);
      rd(4'h0, r);  chk("R2 msel held", r, MSEL_FIELD);

      // R3 / R10 table: control bits with enable clear
      for (int i = 0; i < 6; i++) begin
         wr(4'h4, VEC_W[i]);
         rd(4'h4, r);  chk("R3 control readback", r, VEC_E[i]);
         @(negedge clk);
         chk_phase("R10 no phase move while disabled", 3'd0);
         chk("R10 pull masked", {31'd0, tgt_nconfig}, 32'd1);
      end
      rd(4'h8, r);  chk("R3 pin word idle", r, 32'h0);

      // R7 data writes with port closed (gate set, enable clear)
      wr(4'h4, 32'h102);
      wr(4'hC, 32'hAAAA_5555);
      chk("R7 no valid", {31'd0, tgt_data_vld}, 32'd0);
      rd(4'h0, r);  chk("R7 error set", r, MSEL_FIELD | 32'h100);
      wr(4'h0, 32'h100);
      rd(4'h0, r);  chk("R7 error cleared", r, MSEL_FIELD);

      // R4 enable plus pull
      wr(4'h4, 32'h045);
      chk_phase("R4 phase not yet", 3'd0);
      chk("R4 outputs", {29'd0, tgt_nce, tgt_nconfig, 1'b0}, 32'h0);
      chk("R4 ratio out", {30'd0, cfg_ratio}, 32'd1);
      @(negedge clk);
      chk_phase("R4 reset phase", 3'd1);

      // R5 release pull, wait for status through synchroniser
      wr(4'h4, 32'h001);
      repeat (3) @(negedge clk);
      chk_phase("R5 held without status", 3'd1);
      tgt_nstatus = 1'b1;
      repeat (2) @(negedge clk);
      chk_phase("R5 not early", 3'd1);
      @(negedge clk);
      chk_phase("R5 config phase", 3'd2);

      // R6 forwarding, narrow then wide
      wr(4'h4, 32'h101);
      wr(4'hC, 32'hDEAD_BEEF);
      chk("R6 valid narrow", {31'd0, tgt_data_vld}, 32'd1);
      chk("R6 data narrow", tgt_data, 32'h0000_BEEF);
      wr(4'h4, 32'h301);
      wr(4'hC, 32'h1234_5678);
      chk("R6 data wide", tgt_data, 32'h1234_5678);
      @(negedge clk);
      chk("R6 valid one cycle", {31'd0, tgt_data_vld}, 32'd0);

      // R9 config-done visible after synchroniser
      tgt_conf_done = 1'b1;
      @(negedge clk);
      rd(4'h8, r);  chk("R9 not early", r, 32'h0);
      @(negedge clk);
      rd(4'h8, r);  chk("R9 done bit", r, 32'h400);
      repeat (3) @(negedge clk);
      chk_phase("R8 gate open holds config", 3'd2);

      // R8 close gate, count pulses to user
      wr(4'h4, 32'h201);
      chk_phase("R8 before init", 3'd2);
      pulses = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         rd(4'h0, r);
         if (r[2:0] == 3'd4) break;
         if (tgt_dclk) pulses++;
      end
      chk("R8 pulse count", pulses, 32'd4);
      chk_phase("R8 user phase", 3'd4);

      // R10 disable in user
      wr(4'h4, 32'h200);
      repeat (3) @(negedge clk);
      chk_phase("R10 user kept", 3'd4);
      chk("R10 outputs idle", {30'd0, tgt_nce, tgt_nconfig}, 32'h3);

      // R4 reconfigure from user, R10 disable outside user
      wr(4'h4, 32'h005);
      @(negedge clk);
      chk_phase("R4 reset from user", 3'd1);
      wr(4'h4, 32'h000);
      @(negedge clk);
      chk_phase("R10 back to off", 3'd0);
      chk("R10 ratio idle", {30'd0, cfg_ratio}, 32'd0);

      finish_run();
   end

endmodule